// File: doc/BRIEF.md
# Serial Memory Sequential Read Engine

This block is the slave-side read path of a three-wire serial memory that holds 16-bit words. The host frames a command with a chip-select (`cs`). It clocks command bits in on `di` with a serial clock (`sk`). The block searches the incoming bits for a start bit, then decodes a 2-bit opcode and a word address. For a read command, it fetches the addressed word from an internal register-file model and shifts it out on `do_o`, most significant bit first.

Before the first word, the block drives one zero bit. After that, words follow back to back with no gap. The address steps forward by one after every word and wraps from the last word to word 0. Streaming continues until the host lowers `cs`. Lowering `cs` also aborts any frame in progress and releases the output, which is modelled by `do_oe` going low.

All activity is synchronous to a fast system clock `clk`. The block detects `sk` edges by sampling `sk` on `clk`. The word count `WORDS` (16, 64, 128 or 256) sets the address field width. The register file is preset at reset to a computed pattern. This block does not write to the register file.

Top module: `mw_seqread_top`

## Requirements
- R1: A rising `sk` edge is a `clk` cycle in which `sk` is 1, `sk` was 0 at the previous `clk` edge, and `cs` is 1. Only such edges capture `di` or advance `do_o`. `di` changes while `sk` is steady have no effect, and `sk` edges while `cs` is 0 have no effect.
- R2: A frame consists of any number of leading 0 bits, which are ignored, then a start bit of 1, a 2-bit opcode, and an address of ADDR_BITS bits, all sent MSB first. ADDR_BITS is 6 when WORDS ≤ 64 and 8 otherwise. The opcode 2'b10 selects a read. The word index is the address modulo WORDS.
- R3: In the `clk` cycle that follows the rising `sk` edge carrying the last address bit of a read, `do_oe` becomes 1 and `do_o` becomes 0. This is the dummy bit.
- R4: Each later rising `sk` edge presents the next data bit on `do_o`, bit 15 first and bit 0 last. `do_o` changes in no other cycle.
- R5: The edge after bit 0 of a word presents bit 15 of the word at the next address. No dummy bit is inserted between words.
- R6: The word after index WORDS-1 is index 0.
- R7: When `cs` is 0, `do_oe` is 0 from the next `clk` cycle on and the frame decoder returns to searching for a start bit. A new frame can start once `cs` is 1 again.
- R8: For the opcodes 2'b00, 2'b01 and 2'b11, `do_oe` stays 0 and the remaining bits are ignored until `cs` goes low.
- R9: After reset, word i holds {(i XOR 8'h3C), ~i} in 8-bit halves, with i taken as 8 bits.
- R10: During and right after reset, `do_oe` is 0 and `do_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select; high frames a command |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command and address input |
| do_o | output | 1 | Serial data output |
| do_oe | output | 1 | Output enable for `do_o`; low models high impedance |

## Verification
The assertions assume that `sk`, `cs` and `di` are synchronous to `clk`. They also assume that each `sk` level lasts at least one `clk` sample, so every host edge is seen exactly once. Under these assumptions, a change on `do_o` or a rise of `do_oe` can be traced to one sampled `sk` rise. The stimulus holds each `sk` phase for two or more `clk` cycles, drives every input on the falling `clk` edge, and changes `cs` only while `sk` is low.

// File: rtl/mw_seqread_pkg.sv
// Package: shared types, opcode and reset contents for the sequential read engine.
// Assumes word width of 16 bits and at most 256 words.
package mw_seqread_pkg;

    localparam int WORD_W = 16;
    localparam logic [1:0] OPC_READ = 2'b10;

    typedef enum logic [2:0] {
        DEC_HUNT   = 3'd0,
        DEC_OPC    = 3'd1,
        DEC_ADDR   = 3'd2,
        DEC_STREAM = 3'd3,
        DEC_SKIP   = 3'd4
    } dec_state_e;

    // Reset content of word idx: upper byte idx^3C, lower byte ~idx.
    function automatic logic [WORD_W-1:0] init_word(input int unsigned idx);
        logic [7:0] i8;
        i8 = 8'(idx);
        return {i8 ^ 8'h3C, ~i8};
    endfunction

endpackage

// File: rtl/mw_seqread_decoder.sv
// Frame decoder: searches for the start bit, collects the opcode and the address,
// then either enters streaming (read) or skips the rest of the frame.
// Assumes bit_stb pulses once per qualified serial clock rise while cs is high.
module mw_seqread_decoder
    import mw_seqread_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 bit_stb,
    input  logic                 di,
    output logic                 start_rd,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 streaming
);
    localparam int CNT_W = $clog2(ADDR_BITS);

    dec_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic                 op_hi;
    logic [ADDR_BITS-1:0] addr_sr;
    logic                 last_addr_bit;

    // Last address bit arriving on this strobe.
    assign last_addr_bit = (state == DEC_ADDR) && (cnt == CNT_W'(ADDR_BITS - 1));
    assign start_rd      = bit_stb && last_addr_bit;
    assign rd_addr       = {addr_sr[ADDR_BITS-2:0], di};
    assign streaming     = (state == DEC_STREAM);

    // Frame state machine, reset by rst_n or by cs going low.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            state   <= DEC_HUNT;
            cnt     <= '0;
            op_hi   <= 1'b0;
            addr_sr <= '0;
        end else if (bit_stb) begin
            case (state)
                DEC_HUNT: begin
                    if (di) begin
                        state <= DEC_OPC;
                        cnt   <= '0;
                    end
                end
                DEC_OPC: begin
                    if (cnt == '0) begin
                        op_hi <= di;
                        cnt   <= CNT_W'(1);
                    end else begin
                        cnt <= '0;
                        if ({op_hi, di} == OPC_READ) begin
                            state <= DEC_ADDR;
                        end else begin
                            state <= DEC_SKIP;
                        end
                    end
                end
                DEC_ADDR: begin
                    addr_sr <= {addr_sr[ADDR_BITS-2:0], di};
                    cnt     <= cnt + CNT_W'(1);
                    if (last_addr_bit) begin
                        state <= DEC_STREAM;
                    end
                end
                DEC_STREAM: state <= DEC_STREAM;
                DEC_SKIP:   state <= DEC_SKIP;
                default:    state <= DEC_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/mw_seqread_array.sv
// Register-file model of the word store. Every word is preset at reset to a
// computed pattern; the block has no write path. One combinational read port.
// Assumes WORDS is a power of two.
module mw_seqread_array
    import mw_seqread_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Preset word g at reset; hold afterwards.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= init_word(g);
            end
        end
    end

    // Asynchronous read of the selected word.
    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/mw_seqread_shifter.sv
// Shift-out stage: loads the first word with a zero dummy bit, then shifts
// one bit per strobe and reloads the next word (wrapping) after bit 0.
// Assumes load and shift never pulse in the same cycle.
module mw_seqread_shifter
    import mw_seqread_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              load,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              dout,
    output logic              oe
);
    logic [WORD_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [IDX_W-1:0]  ptr;

    // Read port address: the command address on load, else the next pointer.
    assign rd_idx = load ? load_idx : ptr;

    // Output shift register, bit counter and word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            ptr    <= '0;
            dout   <= 1'b0;
            oe     <= 1'b0;
        end else if (!cs) begin
            oe <= 1'b0;
        end else if (load) begin
            shreg  <= word_in;
            ptr    <= load_idx + IDX_W'(1);
            bitcnt <= '0;
            dout   <= 1'b0;
            oe     <= 1'b1;
        end else if (shift) begin
            dout   <= shreg[WORD_W-1];
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd15) begin
                shreg <= word_in;
                ptr   <= ptr + IDX_W'(1);
            end else begin
                shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/mw_seqread_top.sv
// Top of the sequential read engine: detects serial clock rises on clk,
// decodes frames, and streams words from the register file on do_o.
// Assumes sk, cs and di are synchronous to clk and sk levels last >= 1 clk.
module mw_seqread_top
    import mw_seqread_pkg::*;
#(
    parameter int WORDS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    localparam int IDX_W     = $clog2(WORDS);
    localparam int ADDR_BITS = (WORDS <= 64) ? 6 : 8;

    logic                 sk_q;
    logic                 bit_stb;
    logic                 start_rd;
    logic [ADDR_BITS-1:0] cmd_addr;
    logic                 streaming;
    logic [IDX_W-1:0]     rd_idx;
    logic [WORD_W-1:0]    rd_word;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
        end else begin
            sk_q <= sk;
        end
    end

    assign bit_stb = cs && sk && !sk_q;

    mw_seqread_decoder #(.ADDR_BITS(ADDR_BITS)) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .bit_stb   (bit_stb),
        .di        (di),
        .start_rd  (start_rd),
        .rd_addr   (cmd_addr),
        .streaming (streaming)
    );

    mw_seqread_array #(.WORDS(WORDS), .IDX_W(IDX_W)) arr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    mw_seqread_shifter #(.IDX_W(IDX_W)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .load     (start_rd),
        .load_idx (cmd_addr[IDX_W-1:0]),
        .shift    (bit_stb && streaming),
        .word_in  (rd_word),
        .rd_idx   (rd_idx),
        .dout     (do_o),
        .oe       (do_oe)
    );

endmodule

// File: rtl/mw_seqread_chk.sv
// Checker for the sequential read engine, bound to the top module.
// Assumes inputs synchronous to clk.
module mw_seqread_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sk,
    input logic do_o,
    input logic do_oe
);
    logic sk_d;
    logic rise;

    // Own copy of the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= sk;
    end

    assign rise = cs && sk && !sk_d;

    // R7
    cs_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_oe);

    // R4
    do_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(do_o));

    // R1
    oe_rise_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe) |-> $past(rise));

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe) |-> !do_o);

    // R7
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe |-> $past(cs));

endmodule

bind mw_seqread_top mw_seqread_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .sk    (sk),
    .do_o  (do_o),
    .do_oe (do_oe)
);

// File: tb/mw_seqread_tb.sv
// Directed bench for the sequential read engine.
module mw_seqread_top_tb_top;
    localparam int WORDS = 64;
    localparam int AB    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic do_o;
    logic do_oe;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mw_seqread_top #(.WORDS(WORDS)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .sk    (sk),
        .di    (di),
        .do_o  (do_o),
        .do_oe (do_oe)
    );

    function automatic logic [15:0] exp_word(input int idx);
        logic [7:0] i8;
        i8 = 8'(idx % WORDS);
        return {i8 ^ 8'h3C, ~i8};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One serial bit: sk low two clocks, then rise; sample after the rise.
    task automatic sk_bit(input logic b, output logic got_d, output logic got_oe);
        @(negedge clk);
        di = b;
        sk = 1'b0;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        @(negedge clk);
        got_d  = do_o;
        got_oe = do_oe;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] opc, input int addr, input int lead,
                            output logic d, output logic oe);
        @(negedge clk);
        sk = 1'b0;
        cs = 1'b1;
        for (int i = 0; i < lead; i++) sk_bit(1'b0, d, oe);
        sk_bit(1'b1, d, oe);
        sk_bit(opc[1], d, oe);
        sk_bit(opc[0], d, oe);
        for (int i = AB - 1; i >= 0; i--) sk_bit(addr[i], d, oe);
    endtask

    task automatic read_word(output logic [15:0] w, output logic all_oe);
        logic d, oe;
        all_oe = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0, d, oe);
            w[i] = d;
            all_oe &= oe;
        end
    endtask

    task automatic end_frame();
        @(negedge clk);
        cs = 1'b0;
        sk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 oe after reset", 32'(do_oe), 32'd0);
        chk("R10 do after reset", 32'(do_o), 32'd0);
    endtask

    task automatic t_single();
        logic d, oe, aoe;
        logic [15:0] w;
        send_cmd(2'b10, 5, 0, d, oe);
        chk("R3 dummy oe", 32'(oe), 32'd1);
        chk("R3 dummy bit", 32'(d), 32'd0);
        read_word(w, aoe);
        chk("R4 R9 word 5", 32'(w), 32'(exp_word(5)));
        chk("R4 oe held", 32'(aoe), 32'd1);
        end_frame();
    endtask

    task automatic t_stream();
        logic d, oe, aoe, hold;
        logic [15:0] w;
        send_cmd(2'b10, 10, 0, d, oe);
        read_word(w, aoe);
        chk("R5 word 10", 32'(w), 32'(exp_word(10)));
        hold = do_o;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            di = ~di;
        end
        chk("R1 sk steady no shift", 32'(do_o), 32'(hold));
        read_word(w, aoe);
        chk("R5 word 11 no dummy", 32'(w), 32'(exp_word(11)));
        read_word(w, aoe);
        chk("R5 word 12", 32'(w), 32'(exp_word(12)));
        end_frame();
    endtask

    task automatic t_wrap();
        logic d, oe, aoe;
        logic [15:0] w;
        send_cmd(2'b10, WORDS - 1, 0, d, oe);
        read_word(w, aoe);
        chk("R6 last word", 32'(w), 32'(exp_word(WORDS - 1)));
        read_word(w, aoe);
        chk("R6 wrap to 0", 32'(w), 32'(exp_word(0)));
        end_frame();
    endtask

    task automatic t_leading();
        logic d, oe, aoe;
        logic [15:0] w;
        send_cmd(2'b10, 33, 3, d, oe);
        chk("R2 leading zeros dummy", 32'(oe), 32'd1);
        read_word(w, aoe);
        chk("R2 word 33", 32'(w), 32'(exp_word(33)));
        end_frame();
    endtask

    task automatic t_nonread(input logic [1:0] opc);
        logic d, oe, any_oe;
        send_cmd(opc, 6'h2A, 0, d, oe);
        any_oe = oe;
        for (int i = 0; i < 20; i++) begin
            sk_bit(i[0], d, oe);
            any_oe |= oe;
        end
        chk("R8 non-read oe low", 32'(any_oe), 32'd0);
        end_frame();
    endtask

    task automatic t_abort();
        logic d, oe, aoe;
        logic [15:0] w;
        send_cmd(2'b10, 20, 0, d, oe);
        for (int i = 0; i < 5; i++) sk_bit(1'b0, d, oe);
        @(negedge clk);
        cs = 1'b0;
        sk = 1'b0;
        @(negedge clk);
        chk("R7 oe low after cs", 32'(do_oe), 32'd0);
        // sk edges with cs low are ignored
        for (int i = 0; i < 4; i++) begin
            sk_bit(1'b1, d, oe);
        end
        chk("R1 cs low edges ignored", 32'(do_oe), 32'd0);
        send_cmd(2'b10, 2, 0, d, oe);
        chk("R7 new frame dummy", 32'(oe), 32'd1);
        read_word(w, aoe);
        chk("R7 new frame word 2", 32'(w), 32'(exp_word(2)));
        end_frame();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_stream();
        t_wrap();
        t_leading();
        t_nonread(2'b01);
        t_nonread(2'b11);
        t_nonread(2'b00);
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule